// File: doc/BRIEF.md
# LPC / firmware-hub cycle header decoder

This block sits at the front of a memory target on a 4-bit multiplexed LPC-style bus. It watches the active-low frame strobe and the four shared data lines, and picks out the start code of a new cycle. For firmware-hub cycles it checks a chip-select nibble against a strap input, then gathers a multi-clock memory address and a size nibble. For generic LPC cycles it reads a cycle-type nibble and then an eight-nibble memory address.

When a cycle is claimed, the block sends a single-clock request to the logic behind it. The request carries the direction, the address, the size nibble and a flag that tells the two cycle flavours apart. The claimed cycle stays open until the back end reports it finished. While it is open, the back end may ask for the bus drivers to be enabled. Whenever the frame strobe is sampled low, the drivers are switched off on the next clock and start detection begins again. When nothing is in progress and the strobe is high, the block raises a standby indication.

Top module: `lpc_hdr_decoder`

## Requirements
- R1: After reset, with the frame strobe high, `req` and `lad_oe` are low and `standby` is high.
- R2: A start code of 4'b1101 (read) or 4'b1110 (write), sampled on the last clock with `frame_n` low, followed by a select nibble equal to `strap_sel`, seven address nibbles and one size nibble, produces `req` in the clock after the size nibble, with `req_wr` set for 4'b1110 and `req_lpc` low.
- R3: In a firmware-hub cycle, a select nibble that differs from `strap_sel` produces no request and returns the block to standby.
- R4: Address nibbles arrive most significant first: the first lands in `req_addr[27:24]` and the seventh in `req_addr[3:0]`. `req_size` is the raw size nibble.
- R5: Start code 4'b0000 is followed by a type nibble. When type bits [3:2] are 2'b01 (memory), eight address nibbles follow, `req` rises in the clock after the eighth, `req_addr` holds the last seven nibbles, `req_size` is 0, `req_lpc` is high and `req_wr` equals type bit 1. Any other type produces no request.
- R6: When `frame_n` is sampled low on any clock, `lad_oe` is low in the following clock and any partly received header is dropped without a request.
- R7: When `frame_n` stays low for several clocks, only the nibble on the last low clock is taken as the start code.
- R8: Any other start code produces no request and returns the block to standby.
- R9: `standby` is high exactly when no cycle is in progress and `frame_n` is high. While it is high, `lad_oe` is low.
- R10: Once a cycle is claimed, `lad_oe` follows `drv_req` one clock later until `cyc_done` is sampled high. After that the block is back in standby.
- R11: Each claimed cycle produces `req` for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_i | input | 4 | Nibble sampled from the shared data lines |
| strap_sel | input | 4 | Chip-select value this target answers to |
| drv_req | input | 1 | Back end asks to drive the data lines |
| cyc_done | input | 1 | Back end has finished the claimed cycle |
| lad_oe | output | 1 | Output enable for the data-line drivers |
| standby | output | 1 | Idle with the strobe high |
| req | output | 1 | One-clock request pulse for a claimed cycle |
| req_wr | output | 1 | Request is a write |
| req_lpc | output | 1 | Request came from a generic LPC memory cycle |
| req_addr | output | 28 | Start address of the request |
| req_size | output | 4 | Raw size nibble (0 for LPC cycles) |

## Verification
The bench sweeps every start code against every select or type nibble. This catches a decoder that accepts a wrong code, claims a mismatched select or a non-memory type, or gets the address count of one flavour wrong. If it got the count wrong, the request would arrive a clock early or late and carry a shifted address. Held-low strobes with a different earlier nibble catch a design that latches the first low clock instead of the last. A strobe dropped partway through an address, or while the drivers are on, catches a design that keeps driving the bus or finishes the old header.

// File: rtl/lhd_pkg.sv
package lhd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_ADDR,
      ST_SIZE,
      ST_OWN
   } lhd_state_e;

   typedef enum logic [1:0] {
      K_BAD,
      K_FW_RD,
      K_FW_WR,
      K_LPC
   } lhd_kind_e;

   localparam logic [3:0] CODE_FW_RD = 4'b1101;
   localparam logic [3:0] CODE_FW_WR = 4'b1110;
   localparam logic [3:0] CODE_LPC   = 4'b0000;
   localparam logic [1:0] TYPE_MEM   = 2'b01;
   localparam int unsigned LPC_ADDR_NIBBLES = 8;

endpackage

// File: rtl/lhd_start_dec.sv
module lhd_start_dec
   import lhd_pkg::*;
#(
   parameter bit LPC_EN = 1'b1
) (
   input  logic [3:0] start_nib,
   output lhd_kind_e  kind
);

   lhd_kind_e lpc_kind;

   generate
      if (LPC_EN) begin : g_lpc_on
         assign lpc_kind = K_LPC;
      end else begin : g_lpc_off
         assign lpc_kind = K_BAD;
      end
   endgenerate

   always_comb begin
      case (start_nib)
         CODE_FW_RD: kind = K_FW_RD;
         CODE_FW_WR: kind = K_FW_WR;
         CODE_LPC:   kind = lpc_kind;
         default:    kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/lhd_addr_shift.sv
module lhd_addr_shift #(
   parameter int unsigned ADDR_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic [3:0]        nib,
   output logic [ADDR_W-1:0] addr
);

   generate
      if (ADDR_W == 4) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n || clr)  addr <= '0;
            else if (shift)     addr <= nib;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n || clr)  addr <= '0;
            else if (shift)     addr <= {addr[ADDR_W-5:0], nib};
         end
      end
   endgenerate

endmodule

// File: rtl/lhd_seq.sv
module lhd_seq
   import lhd_pkg::*;
#(
   parameter int unsigned ADDR_NIBBLES = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic [3:0] lad_i,
   input  logic [3:0] strap_sel,
   input  logic       drv_req,
   input  logic       cyc_done,
   input  lhd_kind_e  kind,
   output logic [3:0] start_q,
   output logic       clr,
   output logic       shift_en,
   output logic       req,
   output logic       req_wr,
   output logic       req_lpc,
   output logic [3:0] req_size,
   output logic       lad_oe,
   output logic       standby
);

   localparam int unsigned MAXN  = (ADDR_NIBBLES > LPC_ADDR_NIBBLES) ? ADDR_NIBBLES : LPC_ADDR_NIBBLES;
   localparam int unsigned CNT_W = $clog2(MAXN) + 1;
   localparam logic [CNT_W-1:0] FW_LAST  = CNT_W'(ADDR_NIBBLES - 1);
   localparam logic [CNT_W-1:0] LPC_LAST = CNT_W'(LPC_ADDR_NIBBLES - 1);

   lhd_state_e       state, nxt;
   logic [CNT_W-1:0] cnt;
   logic             fire;
   logic             is_lpc;

   always_comb begin
      nxt      = state;
      clr      = 1'b0;
      shift_en = 1'b0;
      fire     = 1'b0;
      if (!frame_n) begin
         nxt = ST_START;
         clr = 1'b1;
      end else begin
         case (state)
            ST_START: begin
               case (kind)
                  K_FW_RD, K_FW_WR: nxt = (lad_i == strap_sel) ? ST_ADDR : ST_IDLE;
                  K_LPC:            nxt = (lad_i[3:2] == TYPE_MEM) ? ST_ADDR : ST_IDLE;
                  default:          nxt = ST_IDLE;
               endcase
            end
            ST_ADDR: begin
               shift_en = 1'b1;
               if (cnt == '0) begin
                  nxt  = is_lpc ? ST_OWN : ST_SIZE;
                  fire = is_lpc;
               end
            end
            ST_SIZE: begin
               nxt  = ST_OWN;
               fire = 1'b1;
            end
            ST_OWN:  if (cyc_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         start_q  <= '0;
         cnt      <= '0;
         is_lpc   <= 1'b0;
         req_wr   <= 1'b0;
         req_size <= '0;
         req      <= 1'b0;
         lad_oe   <= 1'b0;
      end else begin
         state  <= nxt;
         req    <= fire;
         lad_oe <= frame_n && (nxt == ST_OWN) && drv_req;
         if (!frame_n) start_q <= lad_i;
         if (frame_n && state == ST_START) begin
            is_lpc <= (kind == K_LPC);
            req_wr <= (kind == K_FW_WR) || ((kind == K_LPC) && lad_i[1]);
            cnt    <= (kind == K_LPC) ? LPC_LAST : FW_LAST;
         end
         if (shift_en) cnt <= cnt - 1'b1;
         if (frame_n && state == ST_SIZE) req_size <= lad_i;
         if (fire && is_lpc) req_size <= '0;
      end
   end

   assign req_lpc = is_lpc;
   assign standby = (state == ST_IDLE) && frame_n;

   AST_RELEASE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> !lad_oe); // R6
   AST_RESTART_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> (state == ST_START)); // R6
   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> !req); // R11
   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !lad_oe); // R9
   AST_REQ_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (state == ST_OWN)); // R2

endmodule

// File: rtl/lpc_hdr_decoder.sv
module lpc_hdr_decoder
   import lhd_pkg::*;
#(
   parameter int unsigned ADDR_NIBBLES = 7,
   parameter bit          LPC_EN       = 1'b1,
   localparam int unsigned ADDR_W      = 4 * ADDR_NIBBLES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        lad_i,
   input  logic [3:0]        strap_sel,
   input  logic              drv_req,
   input  logic              cyc_done,
   output logic              lad_oe,
   output logic              standby,
   output logic              req,
   output logic              req_wr,
   output logic              req_lpc,
   output logic [ADDR_W-1:0] req_addr,
   output logic [3:0]        req_size
);

   generate
      if (ADDR_NIBBLES < 1 || ADDR_NIBBLES > 8) begin : g_bad_nibbles
         $error("lpc_hdr_decoder: ADDR_NIBBLES must lie in 1..8");
      end
   endgenerate

   lhd_kind_e  kind;
   logic [3:0] start_q;
   logic       clr;
   logic       shift_en;

   lhd_start_dec #(.LPC_EN(LPC_EN)) u_dec (
      .start_nib (start_q),
      .kind      (kind)
   );

   lhd_seq #(.ADDR_NIBBLES(ADDR_NIBBLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .lad_i     (lad_i),
      .strap_sel (strap_sel),
      .drv_req   (drv_req),
      .cyc_done  (cyc_done),
      .kind      (kind),
      .start_q   (start_q),
      .clr       (clr),
      .shift_en  (shift_en),
      .req       (req),
      .req_wr    (req_wr),
      .req_lpc   (req_lpc),
      .req_size  (req_size),
      .lad_oe    (lad_oe),
      .standby   (standby)
   );

   lhd_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .shift (shift_en),
      .nib   (lad_i),
      .addr  (req_addr)
   );

endmodule

// File: tb/sim_lpc_hdr_decoder.sv
module sim_lpc_hdr_decoder;
   localparam int CLK_NS = 10;
   localparam logic [3:0] STRAP = 4'hA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  lad_i = 4'h0;
   logic [3:0]  strap_sel = STRAP;
   logic        drv_req = 1'b0;
   logic        cyc_done = 1'b0;
   logic        lad_oe, standby, req, req_wr, req_lpc;
   logic [27:0] req_addr;
   logic [3:0]  req_size;

   int checks = 0;
   int errors = 0;
   int req_cnt = 0;

   always #(CLK_NS/2) clk = ~clk;

   always @(posedge clk) if (rst_n && req) req_cnt <= req_cnt + 1;

   lpc_hdr_decoder u0 (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_i(lad_i),
      .strap_sel(strap_sel), .drv_req(drv_req), .cyc_done(cyc_done),
      .lad_oe(lad_oe), .standby(standby), .req(req), .req_wr(req_wr),
      .req_lpc(req_lpc), .req_addr(req_addr), .req_size(req_size)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Sends one header; leaves the claimed cycle open when keep_open is set.
   task automatic run(input logic [3:0] s, input logic [3:0] f, input int pre,
                      input logic [3:0] pre_nib, input bit keep_open);
      logic [3:0]  n [8];
      logic [27:0] ea;
      bit          fw, lpc, hit, ewr;
      int          base;
      string       tg;
      for (int k = 0; k < 8; k++) n[k] = 4'((s * 3 + f * 5 + k * 7 + 1) & 15);
      fw  = (s == 4'hD) || (s == 4'hE);
      lpc = (s == 4'h0);
      hit = (fw && f == STRAP) || (lpc && f[3:2] == 2'b01);
      ewr = fw ? (s == 4'hE) : f[1];
      ea  = '0;
      for (int k = 0; k < (lpc ? 8 : 7); k++) ea = {ea[23:0], n[k]};
      tg  = fw ? ((f == STRAP) ? "R2" : "R3") : (lpc ? "R5" : "R8");
      base = req_cnt;
      for (int p = 0; p < pre; p++) begin
         frame_n = 1'b0; lad_i = pre_nib; @(negedge clk);
      end
      frame_n = 1'b0; lad_i = s; @(negedge clk);
      frame_n = 1'b1; lad_i = f; @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         lad_i = n[k]; @(negedge clk);
      end
      chk({tg, " req after header"}, 32'(req), 32'(hit));
      if (hit) begin
         chk({tg, " req_wr"}, 32'(req_wr), 32'(ewr));
         chk({tg, " req_lpc"}, 32'(req_lpc), 32'(lpc));
         chk("R4 req_addr nibble order", 32'(req_addr), 32'(ea));
         chk("R4 req_size", 32'(req_size), lpc ? 32'd0 : 32'(n[7]));
      end
      lad_i = 4'h0; @(negedge clk);
      chk("R11 req single pulse", 32'(req), 32'd0);
      chk({tg, " request count"}, 32'(req_cnt - base), 32'(hit));
      if (hit && !keep_open) begin
         drv_req = 1'b1; @(negedge clk);
         chk("R10 lad_oe follows drv_req", 32'(lad_oe), 32'd1);
         cyc_done = 1'b1; @(negedge clk);
         cyc_done = 1'b0; drv_req = 1'b0;
         chk("R10 lad_oe off after done", 32'(lad_oe), 32'd0);
         chk("R10 standby after done", 32'(standby), 32'd1);
      end else if (!hit) begin
         chk({tg, " standby after reject"}, 32'(standby), 32'd1);
         chk({tg, " lad_oe quiet"}, 32'(lad_oe), 32'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req at reset", 32'(req), 32'd0);
      chk("R1 lad_oe at reset", 32'(lad_oe), 32'd0);
      chk("R1 standby at reset", 32'(standby), 32'd1);

      // Sweep of every start code against every select/type nibble
      for (int s = 0; s < 16; s++)
         for (int f = 0; f < 16; f++)
            run(4'(s), 4'(f), 0, 4'h0, 1'b0);

      // R7: last low clock wins
      run(4'hD, STRAP, 2, 4'hE, 1'b0);
      run(4'hE, STRAP, 3, 4'hD, 1'b0);
      run(4'hD, STRAP, 1, 4'h0, 1'b0);

      // R6: abort partway through the address, then a full new cycle
      begin
         int base;
         base = req_cnt;
         frame_n = 1'b0; lad_i = 4'hD; @(negedge clk);
         frame_n = 1'b1; lad_i = STRAP; @(negedge clk);
         for (int k = 0; k < 3; k++) begin lad_i = 4'h5; @(negedge clk); end
         frame_n = 1'b0; lad_i = 4'h9; @(negedge clk);
         chk("R6 standby low in frame", 32'(standby), 32'd0);
         frame_n = 1'b1; @(negedge clk);
         chk("R6 aborted header dropped", 32'(req_cnt - base), 32'd0);
         chk("R6 idle after abort", 32'(standby), 32'd1);
         run(4'hE, STRAP, 0, 4'h0, 1'b0);
      end

      // R6: strobe low while drivers are on
      run(4'hD, STRAP, 0, 4'h0, 1'b1);
      drv_req = 1'b1; @(negedge clk);
      chk("R10 lad_oe on in open cycle", 32'(lad_oe), 32'd1);
      frame_n = 1'b0; lad_i = 4'hF; @(negedge clk);
      chk("R6 lad_oe off after strobe", 32'(lad_oe), 32'd0);
      frame_n = 1'b1; @(negedge clk);
      chk("R6 lad_oe stays off", 32'(lad_oe), 32'd0);
      chk("R9 standby after invalid start", 32'(standby), 32'd1);
      drv_req = 1'b0;
      @(negedge clk);
      chk("R9 lad_oe low in standby", 32'(lad_oe), 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule